// File: doc/BRIEF.md
# SPI Master with Register Interface

This block is a memory-mapped SPI master. A small word-addressed register bus gives software four registers: control, status, data and clock divider. Writing the data register while the master bit is set starts one full-duplex exchange. The word is shifted out on MOSI, most significant bit first, while the word arriving on MISO is shifted in. A sticky completion flag reports that the exchange has finished. To receive without sending, software writes an all-ones dummy word and reads the captured word back afterwards.

SCK is derived from the system clock. Its period is the even divider value times the system clock period. The word length runs from 8 to 16 bits. All four clock polarity and phase combinations are supported.

Register map (bus_addr):
- 0 is control: bit 0 is the clock phase, bit 1 is the clock polarity, bit 2 is the master enable, bit 3 is the length enable, and bits 7:4 are the length field.
- 1 is status, read only: bit 0 is done, bit 1 is write collision, bit 2 is busy.
- 2 is data.
- 3 is the clock divider, 8 bits.

Top module: `spi_master_regs`

## Requirements
- R1: After reset, control reads 0, status reads 0, the divider reads 8 and SCK is low.
- R2: A data write (address 2) starts a transfer only when control bit 2 is 1 and no transfer is running. With bit 2 at 0 the write has no effect: SCK does not move and status stays 0.
- R3: A divider write stores the value with bit 0 forced to 0. During a transfer each SCK half period lasts divider/2 system clocks. When idle, SCK rests at the level of control bit 1.
- R4: With control bit 0 at 0, the MSB is on MOSI before the first SCK edge. MISO is sampled on odd (leading) edges and MOSI advances on even (trailing) edges.
- R5: With control bit 0 at 1, MOSI advances on the leading edges after the first. MISO is sampled on the trailing edges.
- R6: The word length is 8 when control bit 3 is 0. When bit 3 is 1, the length equals bits 7:4 for values 8 to 15, and a value of 0 selects 16. Each transfer makes exactly twice the word length of SCK edges.
- R7: Data goes out MSB first. The received word reads from address 2 right-justified, with unused upper bits at 0.
- R8: Status bit 0 (done) is set on the clock that ends the transfer, which is the same clock busy (bit 2) falls. It stays set until it is cleared.
- R9: Done and collision clear only on a data-register access (read or write) that follows a status read. A data access without an earlier status read leaves them set.
- R10: A data write during a transfer sets status bit 1 (collision) and does not disturb the transfer in progress.
- R11: When a transfer ends on the same clock as a clearing data access, the flag is set and stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data of the addressed register, combinational |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
The end of a transfer and a flag-clearing data access can land on the same system clock. In that cycle the completion logic sets done while the clear handshake removes it. The bench provokes this by reading status during a transfer and then placing a data-register read exactly on the clock of the final SCK edge. The count comes from its own edge timing model. It judges the result by reading data and then status afterwards: done must still be set.

// File: rtl/spi_master_regs.sv
module spi_master_regs (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [1:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        spi_sck,
  output logic        spi_mosi,
  input  logic        spi_miso
);
  localparam logic [1:0] A_CTRL = 2'd0, A_STAT = 2'd1, A_DATA = 2'd2, A_DIV = 2'd3;

  logic [7:0]  ctrl, ccr;
  logic        busy, done, wcol, arm, tog;
  logic [4:0]  xlen;
  logic [5:0]  ecnt;
  logic [6:0]  div;
  logic [15:0] sh, rx;

  wire cpha = ctrl[0];
  wire cpol = ctrl[1];
  wire mstr = ctrl[2];
  wire [4:0] len_cfg = !ctrl[3]            ? 5'd8  :
                       (ctrl[7:4] == 4'd0) ? 5'd16 :
                       (ctrl[7:4] < 4'd8)  ? 5'd8  : {1'b0, ctrl[7:4]};
  wire [6:0] half = ccr[7:1];

  wire dacc    = bus_sel && bus_addr == A_DATA;
  wire dwr     = dacc && bus_wr;
  wire srd     = bus_sel && !bus_wr && bus_addr == A_STAT;
  wire start   = dwr && mstr && !busy;
  wire edge_ev = busy && div == half - 7'd1;
  wire lead    = !ecnt[0];
  wire samp    = edge_ev && (cpha ? !lead : lead);
  wire shft    = edge_ev && (cpha ? (lead && ecnt != 6'd0) : !lead);
  wire fin     = edge_ev && (ecnt + 6'd1 == {xlen, 1'b0});
  wire clr     = dacc && arm;
  wire [3:0] msb = 4'(xlen - 5'd1);

  assign spi_sck  = cpol ^ tog;
  assign spi_mosi = sh[msb];

  always_comb
    case (bus_addr)
      A_CTRL:  bus_rdata = {8'd0, ctrl};
      A_STAT:  bus_rdata = {13'd0, busy, wcol, done};
      A_DATA:  bus_rdata = rx;
      default: bus_rdata = {8'd0, ccr};
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ctrl <= '0;
      ccr  <= 8'd8;
    end else if (bus_sel && bus_wr) begin
      if (bus_addr == A_CTRL) ctrl <= bus_wdata[7:0];
      if (bus_addr == A_DIV)  ccr  <= {bus_wdata[7:1], 1'b0};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy <= 1'b0;
      tog  <= 1'b0;
      div  <= '0;
      ecnt <= '0;
      xlen <= 5'd8;
      sh   <= '0;
      rx   <= '0;
    end else if (start) begin
      busy <= 1'b1;
      tog  <= 1'b0;
      div  <= '0;
      ecnt <= '0;
      xlen <= len_cfg;
      sh   <= bus_wdata;
      rx   <= '0;
    end else if (busy) begin
      if (edge_ev) begin
        div  <= '0;
        ecnt <= ecnt + 6'd1;
        tog  <= ~tog;
        if (samp) rx <= {rx[14:0], spi_miso};
        if (shft) sh <= {sh[14:0], 1'b0};
        if (fin)  busy <= 1'b0;
      end else begin
        div <= div + 7'd1;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      arm  <= 1'b0;
      done <= 1'b0;
      wcol <= 1'b0;
    end else begin
      if (dacc)     arm <= 1'b0;
      else if (srd) arm <= 1'b1;
      if (fin)      done <= 1'b1;
      else if (clr) done <= 1'b0;
      if (dwr && busy) wcol <= 1'b1;
      else if (clr)    wcol <= 1'b0;
    end
endmodule

// File: rtl/spi_master_regs_chk.sv
module spi_master_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_sel,
  input logic       bus_wr,
  input logic [1:0] bus_addr,
  input logic [7:0] ctrl,
  input logic       busy,
  input logic       done,
  input logic       wcol,
  input logic       spi_sck
);
  // R3
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> spi_sck == ctrl[1]);
  // R2
  start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == 2'd2 && ctrl[2] && !busy) |=> busy);
  // R2
  no_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == 2'd2 && !ctrl[2] && !busy) |=> !busy);
  // R10
  collision_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == 2'd2 && busy) |=> (wcol && busy));
  // R8
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !(bus_sel && bus_addr == 2'd2)) |=> done);
  // R11
  finish_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
endmodule

bind spi_master_regs spi_master_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .ctrl(ctrl), .busy(busy), .done(done),
  .wcol(wcol), .spi_sck(spi_sck)
);

// File: tb/tb_spi_master_regs.sv
module tb_spi_master_regs;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic spi_sck, spi_mosi;
  logic spi_miso = 1'b0;

  int n_chk = 0, n_err = 0;
  bit finished = 0;

  spi_master_regs dut (.*);

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // behavioural model state
  int m_len, m_h, m_ticks;
  bit m_cpol, m_cpha, m_pend = 0, m_act = 0;
  logic [15:0] m_word, m_slave;

  always @(negedge clk) begin
    if (m_pend) begin
      m_pend = 0;
      m_act  = 1;
      m_ticks = 0;
    end else if (m_act) m_ticks++;
    if (m_act) begin
      int e, sent, got;
      e = m_ticks / m_h;
      if (e > 2*m_len) e = 2*m_len;
      chk(spi_sck == (m_cpol ^ e[0]), "R3", 16'(spi_sck), 16'(m_cpol ^ e[0]));
      if (e < 2*m_len) begin
        sent = m_cpha ? ((e == 0) ? 0 : (e-1)/2) : e/2;
        chk(spi_mosi == m_word[m_len-1-sent], m_cpha ? "R5" : "R4",
            16'(spi_mosi), 16'(m_word[m_len-1-sent]));
      end
      got = m_cpha ? e/2 : (e+1)/2;
      spi_miso = (got < m_len) ? m_slave[m_len-1-got] : 1'b0;
      if (e == 2*m_len) m_act = 0;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk); #1;
    bus_sel = 0;
  endtask

  function automatic int blen(input logic [7:0] c);
    if (!c[3]) return 8;
    if (c[7:4] == 4'd0) return 16;
    return int'(c[7:4]);
  endfunction

  // mode: 0 plain, 1 collision write mid-transfer, 2 clearing access on final edge
  task automatic xfer(input logic [7:0] c, input logic [7:0] k, input logic [15:0] w,
                      input logic [15:0] s, input int mode);
    logic [15:0] d, mask;
    int n;
    wr(2'd0, {8'd0, c});
    wr(2'd3, {8'd0, k});
    m_len = blen(c); m_h = k/2; m_cpol = c[1]; m_cpha = c[0];
    m_word = w; m_slave = s;
    n = 2*m_len*m_h;
    mask = 16'((32'd1 << m_len) - 1);
    wr(2'd2, w);
    m_pend = 1;
    if (mode == 1) begin
      repeat (10) @(posedge clk);
      wr(2'd2, 16'h5A5A);                 // R10 collision
    end else if (mode == 2) begin
      rd(2'd1, d);
      repeat (n-2) @(negedge clk);
      rd(2'd2, d);                        // R11 access lands on the final edge
    end
    wait (!m_pend && !m_act);
    rd(2'd2, d);
    chk(d == (s & mask), "R7", d, s & mask);
    rd(2'd1, d);
    chk(d == ((mode == 1) ? 16'd3 : 16'd1), (mode == 2) ? "R11" : (mode == 1) ? "R10" : "R8",
        d, (mode == 1) ? 16'd3 : 16'd1);
    rd(2'd2, d);
    rd(2'd1, d);
    chk(d == 16'd0, "R9", d, 16'd0);
  endtask

  initial begin
    #(CLK_P*200000);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1
    rd(2'd0, d); chk(d == 16'd0, "R1", d, 16'd0);
    rd(2'd1, d); chk(d == 16'd0, "R1", d, 16'd0);
    rd(2'd3, d); chk(d == 16'd8, "R1", d, 16'd8);
    chk(spi_sck == 1'b0, "R1", 16'(spi_sck), 16'd0);
    // R3 divider forced even
    wr(2'd3, 16'd11);
    rd(2'd3, d); chk(d == 16'd10, "R3", d, 16'd10);
    // R2 no master bit: write ignored
    wr(2'd0, 16'h0002);
    wr(2'd2, 16'h00A5);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk(spi_sck == 1'b1, "R2", 16'(spi_sck), 16'd1);
    end
    rd(2'd1, d); chk(d == 16'd0, "R2", d, 16'd0);
    // R4 R6 mode 0, length enable off
    xfer(8'h04, 8'd8,   16'h00A5, 16'h003C, 0);
    // R5 R6 length 12
    xfer(8'hCD, 8'd10,  16'h0B3E, 16'h05A7, 0);
    // R6 field 0 gives 16
    xfer(8'h0E, 8'd8,   16'hC0DE, 16'h8001, 0);
    // R6 field ignored without enable, mode 3
    xfer(8'hC7, 8'd14,  16'h0081, 16'h006D, 0);
    // R10
    xfer(8'h04, 8'd12,  16'h0096, 16'h0071, 1);
    // R11 length 9, mode 3
    xfer(8'h9F, 8'd8,   16'h01A5, 16'h00F3, 2);
    // R7 dummy all-ones receive at the largest divider
    xfer(8'h04, 8'd254, 16'h00FF, 16'h00C3, 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule